// File: doc/BRIEF.md
# I2C Master SCL Timing Generator

This block produces the SCL waveform for an I2C master. A 16-bit control word sets how long each half of the clock lasts. It holds a speed-class select, a ratio select for the fast class, and a 12-bit count of peripheral clock cycles. While enabled, the block steps through a low phase and then a high phase, over and over. It drives the line low during the low phase and releases it during the high phase, so the output works as an open-drain enable.

A byte engine sitting beside the block uses two single-cycle strobes. One marks the last cycle of each low phase, where SCL is about to rise. The other marks the last cycle of each high phase, where SCL is about to fall. The control word can be rewritten while the clock is running, and the new word is picked up at the next phase boundary. If a count below the legal minimum for its mode is written, the block stores the minimum instead and raises a sticky error flag. As an example, with an 8 MHz peripheral clock a count of 40 in standard mode gives 5 µs per phase, which is a 100 kHz clock.

Top module: `scl_timing_gen`

## Requirements
- R1: The control word has bit 15 = fast class (0 standard, 1 fast), bit 14 = fast ratio select, bits 11:0 = count, and bits 13:12 always zero. `ctrl_q` returns the stored word, with bits 13:12 read as zero whatever was written to them.
- R2: After reset, `ctrl_q` is 0, `cfg_err` is 0, `scl_drive_low` is 0 and neither strobe is asserted.
- R3: In standard mode (bit 15 = 0), the low phase and the high phase each last count cycles.
- R4: In fast mode with bit 14 = 0, the high phase lasts count cycles and the low phase lasts 2 × count cycles.
- R5: In fast mode with bit 14 = 1, the high phase lasts 9 × count cycles and the low phase lasts 16 × count cycles.
- R6: A written count below the minimum for the written mode is stored as that minimum, and `cfg_err` is set in the following cycle. The minimum is 4, or 1 when bits 15 and 14 are both set.
- R7: `cfg_err` stays set until reset, including across later legal writes.
- R8: While `enable` is low, SCL is released, the strobes stay low and the phase counter is held. In the cycle after `enable` is first sampled high, a low phase starts.
- R9: `rise_stb` is high for exactly the last cycle of each low phase, and SCL is released in the next cycle. `fall_stb` is high for exactly the last cycle of each high phase, and SCL is driven low in the next cycle.
- R10: A word written during generation does not change the phase in progress. The next phase takes its length from the word stored at the boundary.
- R11: A stored count of zero, which is the reset value, is generated as the mode minimum.
- R12: `rise_stb` and `fall_stb` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 16 | Control word to write |
| enable | input | 1 | Run SCL generation |
| ctrl_q | output | 16 | Stored control word |
| cfg_err | output | 1 | Sticky flag for an out-of-range count |
| scl_drive_low | output | 1 | 1 = pull SCL low, 0 = release |
| rise_stb | output | 1 | Last cycle of a low phase |
| fall_stb | output | 1 | Last cycle of a high phase |

## Verification
The assertions assume that `enable` and `wr_en` are single-bit levels sampled on the clock. They also assume that the only way a stored count can be zero is reset, since every write goes through the clamp. The stimulus changes every input one time unit after a rising edge and holds `enable` low while reset is active. Because of this, the start-of-low-phase and strobe-to-edge properties only ever see clean level changes. The writes include legal words, words below the minimum in both minimum classes, and words with the reserved bits set. Some writes land in the middle of a phase so that boundary pickup is exercised.

// File: rtl/scl_tg_pkg.sv
package scl_tg_pkg;

   typedef enum logic {
      PH_LOW  = 1'b0,
      PH_HIGH = 1'b1
   } phase_e;

   localparam int unsigned DEF_WORD_W   = 16;
   localparam int unsigned DEF_CNT_W    = 12;
   localparam int unsigned DEF_MIN_STD  = 4;
   localparam int unsigned DEF_MIN_DUTY = 1;

   localparam int unsigned RATIO_FAST_LO = 2;
   localparam int unsigned RATIO_DUTY_HI = 9;
   localparam int unsigned RATIO_DUTY_LO = 16;

endpackage

// File: rtl/scl_tg_ctrl_reg.sv
module scl_tg_ctrl_reg #(
   parameter int unsigned WORD_W   = 16,
   parameter int unsigned CNT_W    = 12,
   parameter int unsigned MIN_STD  = 4,
   parameter int unsigned MIN_DUTY = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [WORD_W-1:0] wr_data,
   output logic              fast_q,
   output logic              duty_q,
   output logic [CNT_W-1:0]  count_q,
   output logic              err_q,
   output logic [WORD_W-1:0] word_q
);

   localparam int unsigned FAST_BIT = WORD_W - 1;
   localparam int unsigned DUTY_BIT = WORD_W - 2;
   localparam logic [CNT_W-1:0] MIN_STD_V  = CNT_W'(MIN_STD);
   localparam logic [CNT_W-1:0] MIN_DUTY_V = CNT_W'(MIN_DUTY);

   logic             wr_fast;
   logic             wr_duty;
   logic [CNT_W-1:0] wr_cnt;
   logic [CNT_W-1:0] wr_min;
   logic             wr_below;
   logic [CNT_W-1:0] wr_cnt_fixed;

   always_comb begin
      wr_fast      = wr_data[FAST_BIT];
      wr_duty      = wr_data[DUTY_BIT];
      wr_cnt       = wr_data[CNT_W-1:0];
      wr_min       = (wr_fast && wr_duty) ? MIN_DUTY_V : MIN_STD_V;
      wr_below     = (wr_cnt < wr_min);
      wr_cnt_fixed = wr_below ? wr_min : wr_cnt;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fast_q  <= 1'b0;
         duty_q  <= 1'b0;
         count_q <= '0;
         err_q   <= 1'b0;
      end else if (wr_en) begin
         fast_q  <= wr_fast;
         duty_q  <= wr_duty;
         count_q <= wr_cnt_fixed;
         if (wr_below) begin
            err_q <= 1'b1;
         end
      end
   end

   always_comb begin
      word_q                = '0;
      word_q[CNT_W-1:0]     = count_q;
      word_q[DUTY_BIT]      = duty_q;
      word_q[FAST_BIT]      = fast_q;
   end

endmodule

// File: rtl/scl_tg_phase_len.sv
module scl_tg_phase_len #(
   parameter int unsigned CNT_W          = 12,
   parameter int unsigned LEN_W          = 16,
   parameter int unsigned MIN_STD        = 4,
   parameter int unsigned MIN_DUTY       = 1,
   parameter bit          USE_SHIFT_ADD  = 1'b1
) (
   input  logic             fast,
   input  logic             duty,
   input  logic [CNT_W-1:0] count,
   output logic [LEN_W-1:0] hi_len,
   output logic [LEN_W-1:0] lo_len
);

   import scl_tg_pkg::*;

   localparam logic [CNT_W-1:0] MIN_STD_V  = CNT_W'(MIN_STD);
   localparam logic [CNT_W-1:0] MIN_DUTY_V = CNT_W'(MIN_DUTY);

   logic [CNT_W-1:0] mode_min;
   logic [CNT_W-1:0] eff_cnt;
   logic [LEN_W-1:0] base;
   logic [LEN_W-1:0] x2;
   logic [LEN_W-1:0] x9;
   logic [LEN_W-1:0] x16;

   always_comb begin
      mode_min = (fast && duty) ? MIN_DUTY_V : MIN_STD_V;
      eff_cnt  = (count < mode_min) ? mode_min : count;
      base     = LEN_W'(eff_cnt);
   end

   if (USE_SHIFT_ADD) begin : g_shift
      always_comb begin
         x2  = base << 1;
         x9  = (base << 3) + base;
         x16 = base << 4;
      end
   end else begin : g_mult
      always_comb begin
         x2  = base * LEN_W'(RATIO_FAST_LO);
         x9  = base * LEN_W'(RATIO_DUTY_HI);
         x16 = base * LEN_W'(RATIO_DUTY_LO);
      end
   end

   always_comb begin
      if (!fast) begin
         hi_len = base;
         lo_len = base;
      end else if (!duty) begin
         hi_len = base;
         lo_len = x2;
      end else begin
         hi_len = x9;
         lo_len = x16;
      end
   end

endmodule

// File: rtl/scl_tg_phase_cnt.sv
module scl_tg_phase_cnt #(
   parameter int unsigned LEN_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             enable,
   input  logic [LEN_W-1:0] next_hi_len,
   input  logic [LEN_W-1:0] next_lo_len,
   output logic             drive_low,
   output logic             rise_stb,
   output logic             fall_stb
);

   import scl_tg_pkg::*;

   localparam logic [LEN_W-1:0] ONE = LEN_W'(1);

   logic             running;
   phase_e           phase;
   logic [LEN_W-1:0] cnt;
   logic [LEN_W-1:0] cur_len;
   logic             at_last;

   always_comb begin
      at_last   = running && (cnt == (cur_len - ONE));
      rise_stb  = at_last && (phase == PH_LOW);
      fall_stb  = at_last && (phase == PH_HIGH);
      drive_low = running && (phase == PH_LOW);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         running <= 1'b0;
         phase   <= PH_LOW;
         cnt     <= '0;
         cur_len <= ONE;
      end else if (!enable) begin
         running <= 1'b0;
         phase   <= PH_LOW;
         cnt     <= '0;
      end else if (!running) begin
         running <= 1'b1;
         phase   <= PH_LOW;
         cnt     <= '0;
         cur_len <= next_lo_len;
      end else if (at_last) begin
         cnt <= '0;
         if (phase == PH_LOW) begin
            phase   <= PH_HIGH;
            cur_len <= next_hi_len;
         end else begin
            phase   <= PH_LOW;
            cur_len <= next_lo_len;
         end
      end else begin
         cnt <= cnt + ONE;
      end
   end

endmodule

// File: rtl/scl_timing_gen.sv
module scl_timing_gen #(
   parameter int unsigned WORD_W        = scl_tg_pkg::DEF_WORD_W,
   parameter int unsigned CNT_W         = scl_tg_pkg::DEF_CNT_W,
   parameter int unsigned MIN_STD       = scl_tg_pkg::DEF_MIN_STD,
   parameter int unsigned MIN_DUTY      = scl_tg_pkg::DEF_MIN_DUTY,
   parameter bit          USE_SHIFT_ADD = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [WORD_W-1:0] wr_data,
   input  logic              enable,
   output logic [WORD_W-1:0] ctrl_q,
   output logic              cfg_err,
   output logic              scl_drive_low,
   output logic              rise_stb,
   output logic              fall_stb
);

   localparam int unsigned LEN_W = CNT_W + 4;

   if (WORD_W < CNT_W + 3) begin : g_bad_word
      $error("scl_timing_gen: WORD_W must leave room for two mode bits and one reserved bit");
   end
   if (MIN_DUTY < 1 || MIN_STD < 1) begin : g_bad_min
      $error("scl_timing_gen: minimum counts must be at least 1");
   end
   if (MIN_STD >= (1 << CNT_W) || MIN_DUTY >= (1 << CNT_W)) begin : g_bad_min_w
      $error("scl_timing_gen: minimum counts must fit in CNT_W");
   end

   logic             fast_q;
   logic             duty_q;
   logic [CNT_W-1:0] count_q;
   logic [LEN_W-1:0] hi_len;
   logic [LEN_W-1:0] lo_len;

   scl_tg_ctrl_reg #(
      .WORD_W  (WORD_W),
      .CNT_W   (CNT_W),
      .MIN_STD (MIN_STD),
      .MIN_DUTY(MIN_DUTY)
   ) u_ctrl (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (wr_en),
      .wr_data(wr_data),
      .fast_q (fast_q),
      .duty_q (duty_q),
      .count_q(count_q),
      .err_q  (cfg_err),
      .word_q (ctrl_q)
   );

   scl_tg_phase_len #(
      .CNT_W        (CNT_W),
      .LEN_W        (LEN_W),
      .MIN_STD      (MIN_STD),
      .MIN_DUTY     (MIN_DUTY),
      .USE_SHIFT_ADD(USE_SHIFT_ADD)
   ) u_len (
      .fast  (fast_q),
      .duty  (duty_q),
      .count (count_q),
      .hi_len(hi_len),
      .lo_len(lo_len)
   );

   scl_tg_phase_cnt #(
      .LEN_W(LEN_W)
   ) u_cnt (
      .clk        (clk),
      .rst_n      (rst_n),
      .enable     (enable),
      .next_hi_len(hi_len),
      .next_lo_len(lo_len),
      .drive_low  (scl_drive_low),
      .rise_stb   (rise_stb),
      .fall_stb   (fall_stb)
   );

endmodule

// File: rtl/scl_timing_gen_chk.sv
module scl_timing_gen_chk #(
   parameter int unsigned WORD_W   = 16,
   parameter int unsigned CNT_W    = 12,
   parameter int unsigned MIN_STD  = 4,
   parameter int unsigned MIN_DUTY = 1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [WORD_W-1:0] wr_data,
   input logic              enable,
   input logic [WORD_W-1:0] ctrl_q,
   input logic              cfg_err,
   input logic              scl_drive_low,
   input logic              rise_stb,
   input logic              fall_stb
);

   localparam logic [CNT_W-1:0] MIN_STD_V  = CNT_W'(MIN_STD);
   localparam logic [CNT_W-1:0] MIN_DUTY_V = CNT_W'(MIN_DUTY);

   logic [CNT_W-1:0] st_min;
   logic [CNT_W-1:0] wr_min;
   always_comb begin
      st_min = (ctrl_q[WORD_W-1] && ctrl_q[WORD_W-2]) ? MIN_DUTY_V : MIN_STD_V;
      wr_min = (wr_data[WORD_W-1] && wr_data[WORD_W-2]) ? MIN_DUTY_V : MIN_STD_V;
   end

   AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_q[WORD_W-3:CNT_W] == '0); // R1
   AST_CNT_AT_LEAST_MIN: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_q[CNT_W-1:0] != '0) |-> (ctrl_q[CNT_W-1:0] >= st_min)); // R6
   AST_LOW_WRITE_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && (wr_data[CNT_W-1:0] < wr_min)) |=> cfg_err); // R6
   AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_err |=> cfg_err); // R7
   AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |=> (!scl_drive_low && !rise_stb && !fall_stb)); // R8
   AST_START_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(enable) |=> scl_drive_low); // R8
   AST_RISE_IN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      rise_stb |-> scl_drive_low); // R9
   AST_FALL_IN_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      fall_stb |-> !scl_drive_low); // R9
   AST_RISE_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
      (rise_stb && enable) |=> !scl_drive_low); // R9
   AST_FALL_PULLS: assert property (@(posedge clk) disable iff (!rst_n)
      (fall_stb && enable) |=> scl_drive_low); // R9
   AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(rise_stb && fall_stb)); // R12

endmodule

bind scl_timing_gen scl_timing_gen_chk #(
   .WORD_W  (WORD_W),
   .CNT_W   (CNT_W),
   .MIN_STD (MIN_STD),
   .MIN_DUTY(MIN_DUTY)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .wr_en        (wr_en),
   .wr_data      (wr_data),
   .enable       (enable),
   .ctrl_q       (ctrl_q),
   .cfg_err      (cfg_err),
   .scl_drive_low(scl_drive_low),
   .rise_stb     (rise_stb),
   .fall_stb     (fall_stb)
);

// File: tb/scl_timing_gen_bench.sv
`timescale 1ns/1ps
module scl_timing_gen_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [15:0] wr_data = 16'h0000;
   logic        enable = 1'b0;
   logic [15:0] ctrl_q;
   logic        cfg_err;
   logic        scl_drive_low;
   logic        rise_stb;
   logic        fall_stb;

   always #5 clk = ~clk;

   scl_timing_gen u_scl_timing_gen (
      .clk          (clk),
      .rst_n        (rst_n),
      .wr_en        (wr_en),
      .wr_data      (wr_data),
      .enable       (enable),
      .ctrl_q       (ctrl_q),
      .cfg_err      (cfg_err),
      .scl_drive_low(scl_drive_low),
      .rise_stb     (rise_stb),
      .fall_stb     (fall_stb)
   );

   int    n_cmp = 0;
   int    n_bad = 0;
   string cur_req = "R2";
   bit    done = 0;

   // reference model state
   int m_fast, m_duty, m_count, m_err;
   int m_run, m_ph, m_pos, m_len;
   int o_fast, o_duty, o_count, w_cnt, w_min;

   function automatic int eff(int f, int d, int c);
      int mn;
      mn = (f == 1 && d == 1) ? 1 : 4;
      return (c < mn) ? mn : c;
   endfunction

   function automatic int low_len(int f, int d, int c);
      int e;
      e = eff(f, d, c);
      if (f == 0) return e;
      if (d == 0) return 2 * e;
      return 16 * e;
   endfunction

   function automatic int high_len(int f, int d, int c);
      int e;
      e = eff(f, d, c);
      if (f == 1 && d == 1) return 9 * e;
      return e;
   endfunction

   task automatic check(string req, string what, int act, int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
      end
   endtask

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_fast = 0; m_duty = 0; m_count = 0; m_err = 0;
         m_run = 0; m_ph = 0; m_pos = 0; m_len = 1;
      end else begin
         o_fast = m_fast; o_duty = m_duty; o_count = m_count;
         if (!enable) begin
            m_run = 0; m_ph = 0; m_pos = 0;
         end else if (m_run == 0) begin
            m_run = 1; m_ph = 0; m_pos = 0;
            m_len = low_len(o_fast, o_duty, o_count);
         end else if (m_pos == m_len - 1) begin
            m_pos = 0;
            m_ph  = 1 - m_ph;
            m_len = (m_ph == 1) ? high_len(o_fast, o_duty, o_count)
                                : low_len(o_fast, o_duty, o_count);
         end else begin
            m_pos++;
         end
         if (wr_en) begin
            m_fast = wr_data[15];
            m_duty = wr_data[14];
            w_cnt  = wr_data[11:0];
            w_min  = (m_fast == 1 && m_duty == 1) ? 1 : 4;
            if (w_cnt < w_min) begin
               w_cnt = w_min;
               m_err = 1;
            end
            m_count = w_cnt;
         end
      end
   end

   // per-cycle comparison away from the active edge
   always @(negedge clk) begin
      if (!done) begin
         int e_low, e_rise, e_fall;
         e_low  = (m_run == 1 && m_ph == 0) ? 1 : 0;
         e_rise = (m_run == 1 && m_ph == 0 && m_pos == m_len - 1) ? 1 : 0;
         e_fall = (m_run == 1 && m_ph == 1 && m_pos == m_len - 1) ? 1 : 0;
         check(cur_req, "scl_drive_low", scl_drive_low, e_low);
         check(cur_req, "rise_stb", rise_stb, e_rise);
         check(cur_req, "fall_stb", fall_stb, e_fall);
         check(cur_req, "ctrl_q", ctrl_q,
               (m_fast << 15) | (m_duty << 14) | m_count);
         check(cur_req, "cfg_err", cfg_err, m_err);
      end
   end

   task automatic wr(logic [15:0] w);
      @(posedge clk); #1;
      wr_en = 1'b1; wr_data = w;
      @(posedge clk); #1;
      wr_en = 1'b0;
   endtask

   task automatic run(int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic finish_run();
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   int cyc = 0;
   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000 && !done) begin
         n_cmp++; n_bad++;
         $display("FAIL watchdog: actual %0d cycles expected below 150000", cyc);
         finish_run();
      end
   end

   initial begin
      cur_req = "R2";
      run(3);
      rst_n = 1'b1;
      run(2);
      check("R2", "ctrl_q after reset", ctrl_q, 0);
      check("R2", "cfg_err after reset", cfg_err, 0);
      check("R2", "scl after reset", scl_drive_low, 0);

      cur_req = "R11";
      enable = 1'b1;
      run(30);

      cur_req = "R8";
      enable = 1'b0;
      run(6);
      check("R8", "released while off", scl_drive_low, 0);

      cur_req = "R1";
      wr(16'h3005);
      check("R1", "reserved bits read zero", ctrl_q, 16'h0005);
      wr(16'h0005);
      check("R1", "count readback", ctrl_q, 16'h0005);
      check("R1", "no error on legal word", cfg_err, 0);

      cur_req = "R8";
      enable = 1'b1;
      run(1);
      check("R8", "low phase first after enable", scl_drive_low, 1);

      cur_req = "R3";
      run(40);
      wr(16'h0028);
      run(200);

      cur_req = "R10";
      run(7);
      wr(16'h8004);
      run(20);

      cur_req = "R4";
      wr(16'h8007);
      run(80);

      cur_req = "R5";
      wr(16'hC001);
      run(80);
      wr(16'hC002);
      run(150);

      cur_req = "R9";
      wr(16'h0004);
      run(60);

      cur_req = "R12";
      wr(16'h8004);
      run(40);

      cur_req = "R6";
      check("R6", "flag clear before bad write", cfg_err, 0);
      wr(16'h0002);
      check("R6", "standard count clamped to 4", ctrl_q, 16'h0004);
      check("R6", "flag set", cfg_err, 1);
      wr(16'hC000);
      check("R6", "fast-ratio count clamped to 1", ctrl_q, 16'hC001);
      run(60);

      cur_req = "R7";
      wr(16'h0010);
      check("R7", "flag survives legal write", cfg_err, 1);
      run(50);
      enable = 1'b0;
      rst_n = 1'b0;
      run(2);
      cur_req = "R2";
      check("R7", "flag cleared by reset", cfg_err, 0);
      rst_n = 1'b1;
      run(4);
      finish_run();
   end

endmodule